// File: doc/BRIEF.md
# Endian-Configurable Load/Store Byte Aligner

This block sits between a 32-bit register file and a 32-bit external data bus. It formats the data for byte and word transfers. Its inputs are the access size, the transfer direction, the two low address bits and an endianness select. On a load it picks or rotates the incoming bus word into a register result. On a store it builds the outgoing bus word and a set of per-lane write enables.

Byte loads pick one bus lane and zero-extend it. Word loads at an offset that is not a multiple of four are rotated rather than faulted, so that a later shift can extract a half-word. Byte stores copy the source byte onto every lane, and the enables tell memory which lane to write. Word stores pass the register through untouched.

The datapath is combinational. A parameter adds an output register stage, which is on by default. With the default, every output reflects the inputs sampled at the previous rising clock edge.

Top module: `ldst_lane_aligner`

## Requirements
- R1: While rst_n is low, bus_wdata, load_result and lane_we are all zero. After reset, each output shows the result for the inputs sampled at the previous rising clock edge.
- R2: Byte load (acc_word=0, is_store=0) lane mapping. With big_end=0, offset k selects bus_rdata bits 8k+7:8k. With big_end=1, offset k selects bits 8(3-k)+7:8(3-k), so offset 0 gives bits 31:24 and offset 3 gives bits 7:0.
- R3: A byte load places the selected byte in load_result[7:0] and drives load_result[31:8] to zero.
- R4: A word load (acc_word=1, is_store=0) returns bus_rdata rotated right by 8 × offset in both endian modes. With big_end=1, offsets 0 and 2 put the addressed byte in bits 31:24, and offsets 1 and 3 put it in bits 15:8. With big_end=0, the addressed byte lands in bits 7:0.
- R5: A byte store (acc_word=0, is_store=1) drives reg_wdata[7:0] onto all four byte lanes of bus_wdata.
- R6: A word store (acc_word=1, is_store=1) drives reg_wdata to bus_wdata bit for bit, whatever the offset.
- R7: A byte store raises exactly one lane_we bit, where bit k covers bus bits 8k+7:8k. That bit is k for offset k with big_end=0, and 3-k with big_end=1.
- R8: A word store raises all four lane_we bits. A load raises none.
- R9: During a store load_result is zero, and during a load bus_wdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| is_store | input | 1 | 1 = store, 0 = load |
| addr_lo | input | 2 | Address bits 1:0 (byte offset) |
| big_end | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| reg_wdata | input | 32 | Source register data for stores |
| bus_rdata | input | 32 | Read data from the external bus |
| bus_wdata | output | 32 | Formatted write data to the bus |
| load_result | output | 32 | Formatted value for the destination register |
| lane_we | output | 4 | Per-lane write enables |

## Verification
The assertions compare registered outputs with the inputs seen one edge earlier. They therefore assume that every control and data input has a known value and is stable around each rising edge. They also assume the output stage is present. The bench meets this by giving all inputs defined values at time zero and by changing them only on falling edges. It holds each input set for a whole cycle and keeps the offset within its two-bit range. It sweeps every offset, size, direction and endianness against its own rotation and replication model.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/lsa_lane_sel.sv
module lsa_lane_sel #(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             big_end,
  output logic [OFS_W-1:0] lane_idx,
  output logic [LANES-1:0] lane_oh
);
  // Big-endian mirrors the offset: offset 0 is the most significant lane.
  always_comb begin
    if (big_end) lane_idx = OFS_W'(LANES - 1) - ofs;
    else         lane_idx = ofs;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_oh
    assign lane_oh[k] = (lane_idx == OFS_W'(k));
  end

  always_comb begin
    assert ($countones(lane_oh) == 1) else $error("AST_LANE_ONEHOT"); // R7
  end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
  import lsa_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int OFS_W  = $clog2(LANES),
  localparam int DATA_W = LANE_W * LANES
) (
  input  acc_kind_e          kind,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [OFS_W-1:0]   lane_idx,
  input  logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  result
);
  logic [DATA_W-1:0] rot;
  logic [LANE_W-1:0] pick;

  // Rotate right by whole lanes: result lane j takes read lane (j + ofs).
  for (genvar j = 0; j < LANES; j++) begin : g_rot
    logic [OFS_W-1:0] src;
    assign src = ofs + OFS_W'(j);
    assign rot[j*LANE_W +: LANE_W] = rdata[src*LANE_W +: LANE_W];
  end

  assign pick = rdata[lane_idx*LANE_W +: LANE_W];

  always_comb begin
    if (kind == ACC_WORD) result = rot;
    else                  result = {{(DATA_W-LANE_W){1'b0}}, pick};
  end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path
  import lsa_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  acc_kind_e          kind,
  input  logic [LANES-1:0]   lane_oh,
  input  logic [DATA_W-1:0]  src,
  output logic [DATA_W-1:0]  wdata,
  output logic [LANES-1:0]   we
);
  logic [DATA_W-1:0] repl;

  for (genvar k = 0; k < LANES; k++) begin : g_repl
    assign repl[k*LANE_W +: LANE_W] = src[LANE_W-1:0];
  end

  always_comb begin
    if (kind == ACC_WORD) begin
      wdata = src;
      we    = '1;
    end else begin
      wdata = repl;
      we    = lane_oh;
    end
  end
endmodule

// File: rtl/ldst_lane_aligner.sv
module ldst_lane_aligner
  import lsa_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int OFS_W  = $clog2(LANES),
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_word,
  input  logic              is_store,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic              big_end,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] load_result,
  output logic [LANES-1:0]  lane_we
);
  acc_kind_e         kind;
  logic [OFS_W-1:0]  lane_idx;
  logic [LANES-1:0]  lane_oh;
  logic [DATA_W-1:0] ld_res, st_data;
  logic [LANES-1:0]  st_we;
  logic [DATA_W-1:0] wdata_nx, result_nx;
  logic [LANES-1:0]  we_nx;

  assign kind = acc_kind_e'(acc_word);

  lsa_lane_sel #(.LANES(LANES)) u_sel (
    .ofs(addr_lo), .big_end(big_end), .lane_idx(lane_idx), .lane_oh(lane_oh)
  );

  lsa_load_path #(.LANE_W(LANE_W), .LANES(LANES)) u_ld (
    .kind(kind), .ofs(addr_lo), .lane_idx(lane_idx), .rdata(bus_rdata),
    .result(ld_res)
  );

  lsa_store_path #(.LANE_W(LANE_W), .LANES(LANES)) u_st (
    .kind(kind), .lane_oh(lane_oh), .src(reg_wdata), .wdata(st_data),
    .we(st_we)
  );

  // Next-state: gate each path by direction.
  always_comb begin
    if (is_store) begin
      wdata_nx  = st_data;
      we_nx     = st_we;
      result_nx = '0;
    end else begin
      wdata_nx  = '0;
      we_nx     = '0;
      result_nx = ld_res;
    end
  end

  if (OUT_REG) begin : g_oreg
    logic              ld_en;
    logic [DATA_W-1:0] wdata_q, result_q;
    logic [LANES-1:0]  we_q;

    assign ld_en = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wdata_q  <= '0;
        result_q <= '0;
        we_q     <= '0;
      end else if (ld_en) begin
        wdata_q  <= wdata_nx;
        result_q <= result_nx;
        we_q     <= we_nx;
      end
    end

    assign bus_wdata   = wdata_q;
    assign load_result = result_q;
    assign lane_we     = we_q;

    AST_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_store |=> (lane_we == '0 && bus_wdata == '0)) else $error("AST_LOAD_NO_WE"); // R8
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_store && !acc_word) |=> (load_result[DATA_W-1:LANE_W] == '0)) else $error("AST_BYTE_ZEXT"); // R3
    AST_WORD_STORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_store && acc_word) |=> (bus_wdata == $past(reg_wdata) && lane_we == '1)) else $error("AST_WORD_STORE_PASS"); // R6
    AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_store && !acc_word) |=> ($countones(lane_we) == 1)) else $error("AST_BYTE_STORE_ONE_LANE"); // R7
    AST_BYTE_STORE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_store && !acc_word) |=> (bus_wdata == {LANES{$past(reg_wdata[LANE_W-1:0])}})) else $error("AST_BYTE_STORE_REPL"); // R5
    AST_STORE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      is_store |=> (load_result == '0)) else $error("AST_STORE_NO_RESULT"); // R9
  end else begin : g_comb
    assign bus_wdata   = wdata_nx;
    assign load_result = result_nx;
    assign lane_we     = we_nx;
  end
endmodule

// File: tb/sim_ldst_lane_aligner.sv
module sim_ldst_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_word = 1'b0, is_store = 1'b0, big_end = 1'b0;
  logic [1:0]  addr_lo = 2'd0;
  logic [31:0] reg_wdata = 32'h0, bus_rdata = 32'h0;
  logic [31:0] bus_wdata, load_result;
  logic [3:0]  lane_we;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldst_lane_aligner u0 (
    .clk(clk), .rst_n(rst_n), .acc_word(acc_word), .is_store(is_store),
    .addr_lo(addr_lo), .big_end(big_end), .reg_wdata(reg_wdata),
    .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .load_result(load_result),
    .lane_we(lane_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Apply at a falling edge, let one rising edge capture, sample at the next falling edge.
  task automatic drive(input logic w, input logic st, input logic [1:0] ofs,
                       input logic be, input logic [31:0] rw, input logic [31:0] rd);
    @(negedge clk);
    acc_word = w; is_store = st; addr_lo = ofs; big_end = be;
    reg_wdata = rw; bus_rdata = rd;
    @(negedge clk);
  endtask

  function automatic int lane_of(input int k, input bit be);
    return be ? 3 - k : k;
  endfunction

  function automatic logic [31:0] rot_r(input logic [31:0] x, input int k);
    logic [63:0] d;
    d = {x, x} >> (8 * k);
    return d[31:0];
  endfunction

  task automatic t_reset;
    @(negedge clk);
    acc_word = 1'b1; is_store = 1'b1; reg_wdata = 32'hDEADBEEF; bus_rdata = 32'hCAFEF00D;
    @(negedge clk);
    chk("R1 reset bus_wdata", bus_wdata, 32'h0);
    chk("R1 reset load_result", load_result, 32'h0);
    chk("R1 reset lane_we", {28'h0, lane_we}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle word store", bus_wdata, 32'hDEADBEEF);
  endtask

  task automatic t_byte_load;
    logic [31:0] pats [3] = '{32'hA1B2C3D4, 32'hFF00FF00, 32'h80808080};
    for (int p = 0; p < 3; p++)
      for (int be = 0; be < 2; be++)
        for (int k = 0; k < 4; k++) begin
          logic [31:0] exp;
          exp = {24'h0, pats[p][8*lane_of(k, be[0]) +: 8]};
          drive(1'b0, 1'b0, 2'(k), be[0], 32'h12345678, pats[p]);
          chk($sformatf("R2 R3 byte load be=%0d ofs=%0d", be, k), load_result, exp);
          chk("R8 R9 byte load no write", {lane_we, bus_wdata[27:0]}, 32'h0);
        end
  endtask

  task automatic t_word_load;
    logic [31:0] pats [2] = '{32'hA1B2C3D4, 32'h01234567};
    for (int p = 0; p < 2; p++)
      for (int be = 0; be < 2; be++)
        for (int k = 0; k < 4; k++) begin
          drive(1'b1, 1'b0, 2'(k), be[0], 32'h0, pats[p]);
          chk($sformatf("R4 word load be=%0d ofs=%0d", be, k), load_result, rot_r(pats[p], k));
          if (be == 1 && (k == 1 || k == 3))
            chk("R4 BE addressed byte at 15:8", {24'h0, load_result[15:8]}, {24'h0, pats[p][8*(3-k) +: 8]});
          if (be == 0)
            chk("R4 LE addressed byte at 7:0", {24'h0, load_result[7:0]}, {24'h0, pats[p][8*k +: 8]});
          chk("R8 word load no enables", {28'h0, lane_we}, 32'h0);
        end
  endtask

  task automatic t_byte_store;
    for (int be = 0; be < 2; be++)
      for (int k = 0; k < 4; k++) begin
        drive(1'b0, 1'b1, 2'(k), be[0], 32'h55AA_0F00 | 32'(k + 16 * be), 32'hFFFFFFFF);
        chk($sformatf("R5 byte store repl be=%0d ofs=%0d", be, k), bus_wdata,
            {4{8'(k + 16 * be)}});
        chk($sformatf("R7 byte store lane be=%0d ofs=%0d", be, k), {28'h0, lane_we},
            32'(1 << lane_of(k, be[0])));
        chk("R9 byte store result zero", load_result, 32'h0);
      end
  endtask

  task automatic t_word_store;
    for (int be = 0; be < 2; be++)
      for (int k = 0; k < 4; k++) begin
        drive(1'b1, 1'b1, 2'(k), be[0], 32'h8765_4321 ^ 32'(k), 32'hA5A5A5A5);
        chk($sformatf("R6 word store be=%0d ofs=%0d", be, k), bus_wdata, 32'h8765_4321 ^ 32'(k));
        chk("R8 word store all enables", {28'h0, lane_we}, 32'hF);
        chk("R9 word store result zero", load_result, 32'h0);
      end
  endtask

  initial begin
    t_reset();
    t_byte_load();
    t_word_load();
    t_byte_store();
    t_word_store();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule